// File: doc/BRIEF.md
# Prioritized Atomic-Aware Bus Command Issuer

This block sits between the two level-one caches of a processor and a split-transaction bus. It collects up to eight kinds of outstanding request as sticky flags. The kinds are data miss, data uncached read, instruction miss, instruction uncached read, buffered write, linked load, store-conditional and compare-and-swap. Whenever it is idle, it picks the most urgent one and drives it onto the bus as one or two command flits. Each flit is held on the bus until the bus acknowledges it.

Linked loads go out as locked reads. The responder is expected to return two flits: the data and a reservation key. A store-conditional goes out as a two-flit packet: the first flit carries the key obtained from the earlier linked load, and the second carries the value to store. A compare-and-swap sends the expected old value and then the new value. A linked load waits while the write buffer still holds a write to the same word, so that the locked read cannot overtake that store.

The requesting side keeps the operand inputs stable from the set pulse until the request's last flit has been accepted.

Top module: `atomic_cmd_issuer`

## Requirements
- R1: After reset no command is valid and no request is pending; `cmd_val` stays low until a request is raised.
- R2: A one-cycle pulse on bit k of `req_set` records a pending request that persists until that request is taken into the issuing state. The flag is cleared in that same cycle. A new pulse that arrives while a command is in flight is kept.
- R3: Among pending eligible requests, the lowest `req_set` index wins. The order from highest to lowest is: 0 data miss, 1 data uncached read, 2 instruction miss, 3 instruction uncached read, 4 buffered write, 5 linked load, 6 store-conditional, 7 compare-and-swap.
- R4: A linked load is not taken while `wb_hold` is high and `wb_hold_addr` addresses the same word as `d_addr`. Lower-priority requests are issued past it in the meantime. It is issued once the hazard clears or when the addresses differ.
- R5: A linked load is one flit with code 3 (locked read), type 6 and length 2*DW/8. Write data is zero, all byte enables are set and end-of-packet is high.
- R6: A store-conditional is two flits with code 0 (no-op) and type 7, and length 2*DW/8. Flit one carries `sc_key` with end-of-packet low. Flit two carries `sc_data` with end-of-packet high.
- R7: A compare-and-swap is two flits with code 0 and type 5, and length 2*DW/8. Flit one carries `cas_old` and flit two carries `cas_new`. End-of-packet is high on flit two only.
- R8: Read commands are single flits with code 1 (read), zero write data and all byte enables set. The data miss uses type 1 and the instruction miss uses type 3; both have length LINE_WORDS*DW/8 and an address cleared to the line. The data uncached read uses type 0 and the instruction uncached read uses type 2; both have length DW/8.
- R9: A buffered write is a single flit with code 2 (write), type 4 and length DW/8. It carries `wr_data` and `wr_be` to `wr_addr`.
- R10: Every atomic and uncached command carries its address with the low log2(DW/8) bits cleared. Linked load, store-conditional and compare-and-swap use `d_addr`.
- R11: A flit stays on the bus, with all its fields unchanged, until `cmd_ack` is high. The flit position advances only on an acknowledged cycle.
- R12: After the last flit of a packet is acknowledged, the issuer is idle for one cycle, with `cmd_val` low, before the next packet starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 8 | One-cycle request pulses, index = priority (0 highest) |
| d_addr | input | AW | Data-side physical address (misses, uncached, atomics) |
| i_addr | input | AW | Instruction-side physical address |
| wr_addr | input | AW | Address of the buffered write |
| wr_data | input | DW | Data of the buffered write |
| wr_be | input | DW/8 | Byte enables of the buffered write |
| wb_hold | input | 1 | Write buffer still holds a write not yet completed |
| wb_hold_addr | input | AW | Address of that held write |
| sc_key | input | DW | Reservation key for the store-conditional |
| sc_data | input | DW | Value stored by the store-conditional |
| cas_old | input | DW | Expected old value for compare-and-swap |
| cas_new | input | DW | New value for compare-and-swap |
| cmd_ack | input | 1 | Bus accepts the current flit |
| cmd_val | output | 1 | A command flit is presented |
| cmd_addr | output | AW | Flit address |
| cmd_wdata | output | DW | Flit write data |
| cmd_be | output | DW/8 | Flit byte enables |
| cmd_type | output | 3 | Packet type id |
| cmd_plen | output | PLEN_W | Packet length in bytes |
| cmd_code | output | 2 | Command code: 0 no-op, 1 read, 2 write, 3 locked read |
| cmd_eop | output | 1 | Last flit of the packet |

## Verification
The bench raises all eight requests in one cycle and expects them in strict priority order. A design with a swapped priority comparison, or one that clears the wrong flag, would reorder or drop packets. A same-word write hazard is held against a linked load while a store-conditional is pending. A design that ignored the hazard would let the locked read out too early, and one that stalled the whole arbiter would starve the store-conditional. Acknowledge is withheld on irregular cycles, including between the two flits of an atomic packet. This catches a flit counter that advances without acknowledge, an end-of-packet raised on the key or old-value flit, and a missing idle cycle after the packet. A request raised during an in-flight compare-and-swap must survive to be issued next.

// File: rtl/atomic_cmd_issuer.sv
module atomic_cmd_issuer #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 8,
  parameter int PLEN_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        req_set,
  input  logic [AW-1:0]     d_addr,
  input  logic [AW-1:0]     i_addr,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW/8-1:0]   wr_be,
  input  logic              wb_hold,
  input  logic [AW-1:0]     wb_hold_addr,
  input  logic [DW-1:0]     sc_key,
  input  logic [DW-1:0]     sc_data,
  input  logic [DW-1:0]     cas_old,
  input  logic [DW-1:0]     cas_new,
  input  logic              cmd_ack,
  output logic              cmd_val,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_wdata,
  output logic [DW/8-1:0]   cmd_be,
  output logic [2:0]        cmd_type,
  output logic [PLEN_W-1:0] cmd_plen,
  output logic [1:0]        cmd_code,
  output logic              cmd_eop
);

  localparam int BEW        = DW / 8;
  localparam int LINE_BYTES = LINE_WORDS * BEW;
  localparam int WOFF       = $clog2(BEW);
  localparam int LOFF       = $clog2(LINE_BYTES);

  localparam logic [1:0] C_NOP = 2'd0, C_READ = 2'd1, C_WRITE = 2'd2, C_LOCKED = 2'd3;
  localparam logic [2:0] T_DUNC = 3'd0, T_DMISS = 3'd1, T_IUNC = 3'd2, T_IMISS = 3'd3,
                         T_WR = 3'd4, T_CAS = 3'd5, T_LL = 3'd6, T_SC = 3'd7;

  typedef enum logic [3:0] {
    S_IDLE, S_DMISS, S_DUNC, S_IMISS, S_IUNC, S_WRITE, S_LL, S_SC, S_CAS
  } st_t;

  st_t        st;
  logic       second;
  logic [7:0] pend, elig, take;
  logic [2:0] sel;
  logic       sel_ok, ll_block, two_flit;

  logic unused_low;
  assign unused_low = ^{d_addr[WOFF-1:0], i_addr[WOFF-1:0], wr_addr[WOFF-1:0], wb_hold_addr[WOFF-1:0]};

  assign ll_block = wb_hold && (wb_hold_addr[AW-1:WOFF] == d_addr[AW-1:WOFF]);
  assign elig     = pend & ~{2'b00, ll_block, 5'b00000};
  assign two_flit = (st == S_SC) || (st == S_CAS);

  always_comb begin
    sel_ok = 1'b0;
    sel    = 3'd0;
    for (int k = 7; k >= 0; k--)
      if (elig[k]) begin
        sel_ok = 1'b1;
        sel    = 3'(k);
      end
  end

  assign take = (st == S_IDLE && sel_ok) ? (8'd1 << sel) : 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      st     <= S_IDLE;
      second <= 1'b0;
    end else begin
      pend <= (pend & ~take) | req_set;
      if (st == S_IDLE) begin
        second <= 1'b0;
        if (sel_ok) st <= st_t'(4'(sel) + 4'd1);
      end else if (cmd_ack) begin
        if (two_flit && !second) second <= 1'b1;
        else begin
          st     <= S_IDLE;
          second <= 1'b0;
        end
      end
    end
  end

  logic [AW-1:0] d_word, d_line, i_word, i_line;
  assign d_word = {d_addr[AW-1:WOFF], {WOFF{1'b0}}};
  assign d_line = {d_addr[AW-1:LOFF], {LOFF{1'b0}}};
  assign i_word = {i_addr[AW-1:WOFF], {WOFF{1'b0}}};
  assign i_line = {i_addr[AW-1:LOFF], {LOFF{1'b0}}};

  assign cmd_val = (st != S_IDLE);
  assign cmd_eop = cmd_val && (!two_flit || second);

  always_comb begin
    cmd_addr  = d_word;
    cmd_wdata = '0;
    cmd_be    = '1;
    cmd_type  = T_DUNC;
    cmd_plen  = PLEN_W'(BEW);
    cmd_code  = C_READ;
    case (st)
      S_DMISS: begin cmd_addr = d_line; cmd_type = T_DMISS; cmd_plen = PLEN_W'(LINE_BYTES); end
      S_DUNC:  ;
      S_IMISS: begin cmd_addr = i_line; cmd_type = T_IMISS; cmd_plen = PLEN_W'(LINE_BYTES); end
      S_IUNC:  begin cmd_addr = i_word; cmd_type = T_IUNC; end
      S_WRITE: begin
        cmd_addr  = {wr_addr[AW-1:WOFF], {WOFF{1'b0}}};
        cmd_wdata = wr_data;
        cmd_be    = wr_be;
        cmd_type  = T_WR;
        cmd_code  = C_WRITE;
      end
      S_LL:  begin cmd_type = T_LL; cmd_plen = PLEN_W'(2 * BEW); cmd_code = C_LOCKED; end
      S_SC:  begin
        cmd_wdata = second ? sc_data : sc_key;
        cmd_type  = T_SC; cmd_plen = PLEN_W'(2 * BEW); cmd_code = C_NOP;
      end
      S_CAS: begin
        cmd_wdata = second ? cas_new : cas_old;
        cmd_type  = T_CAS; cmd_plen = PLEN_W'(2 * BEW); cmd_code = C_NOP;
      end
      default: begin cmd_be = '0; cmd_plen = '0; cmd_code = C_NOP; end
    endcase
  end

  AST_LL_NO_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LL && $past(st) == S_IDLE) |-> !$past(ll_block)); // R4
  AST_FLIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_val && !cmd_ack) |=> (cmd_val && $stable(cmd_type) && $stable(cmd_eop) && $stable(cmd_code))); // R11
  AST_SC_SECOND_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_val && cmd_type == T_SC && !cmd_eop && cmd_ack) |=> (cmd_val && cmd_type == T_SC && cmd_eop)); // R6
  AST_ATOMIC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_val && (cmd_type == T_LL || cmd_type == T_SC || cmd_type == T_CAS)) |-> (cmd_addr[WOFF-1:0] == '0)); // R10
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_val && cmd_ack && cmd_eop) |=> !cmd_val); // R12

endmodule

// File: tb/test_atomic_cmd_issuer.sv
module test_atomic_cmd_issuer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  req_set = '0;
  logic [31:0] d_addr = '0, i_addr = '0, wr_addr = '0, wb_hold_addr = '0;
  logic [31:0] wr_data = '0, sc_key = '0, sc_data = '0, cas_old = '0, cas_new = '0;
  logic [3:0]  wr_be = '0;
  logic        wb_hold = 0;
  logic        cmd_ack = 0;
  logic        cmd_val, cmd_eop;
  logic [31:0] cmd_addr, cmd_wdata;
  logic [3:0]  cmd_be;
  logic [2:0]  cmd_type;
  logic [7:0]  cmd_plen;
  logic [1:0]  cmd_code;

  always #5 clk = ~clk;

  atomic_cmd_issuer i_atomic_cmd_issuer (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .d_addr(d_addr), .i_addr(i_addr),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wb_hold(wb_hold),
    .wb_hold_addr(wb_hold_addr), .sc_key(sc_key), .sc_data(sc_data),
    .cas_old(cas_old), .cas_new(cas_new), .cmd_ack(cmd_ack), .cmd_val(cmd_val),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be), .cmd_type(cmd_type),
    .cmd_plen(cmd_plen), .cmd_code(cmd_code), .cmd_eop(cmd_eop));

  typedef struct {
    logic [84:0] bits;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   ack_mode = 0;
  int   cyc = 0;
  bit   idle_due = 0;

  task automatic check(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  function automatic logic [84:0] pack(logic [31:0] a, logic [31:0] w, logic [3:0] be,
                                       logic [2:0] t, logic [7:0] pl, logic [1:0] c, logic e);
    return {a, w, be, t, pl, c, e};
  endfunction

  task automatic push(logic [84:0] b, string tag);
    exp_t x;
    x.bits = b;
    x.tag  = tag;
    q.push_back(x);
  endtask

  task automatic push_req(int k, string tag);
    logic [31:0] dw, dl, iw, il;
    dw = {d_addr[31:2], 2'b00};
    dl = {d_addr[31:5], 5'b0};
    iw = {i_addr[31:2], 2'b00};
    il = {i_addr[31:5], 5'b0};
    case (k)
      0: push(pack(dl, 0, 4'hF, 3'd1, 8'd32, 2'd1, 1), tag == "" ? "R8" : tag);
      1: push(pack(dw, 0, 4'hF, 3'd0, 8'd4, 2'd1, 1), tag == "" ? "R8" : tag);
      2: push(pack(il, 0, 4'hF, 3'd3, 8'd32, 2'd1, 1), tag == "" ? "R8" : tag);
      3: push(pack(iw, 0, 4'hF, 3'd2, 8'd4, 2'd1, 1), tag == "" ? "R8" : tag);
      4: push(pack({wr_addr[31:2], 2'b00}, wr_data, wr_be, 3'd4, 8'd4, 2'd2, 1), tag == "" ? "R9" : tag);
      5: push(pack(dw, 0, 4'hF, 3'd6, 8'd8, 2'd3, 1), tag == "" ? "R5" : tag);
      6: begin
        push(pack(dw, sc_key, 4'hF, 3'd7, 8'd8, 2'd0, 0), tag == "" ? "R6" : tag);
        push(pack(dw, sc_data, 4'hF, 3'd7, 8'd8, 2'd0, 1), tag == "" ? "R6" : tag);
      end
      default: begin
        push(pack(dw, cas_old, 4'hF, 3'd5, 8'd8, 2'd0, 0), tag == "" ? "R7" : tag);
        push(pack(dw, cas_new, 4'hF, 3'd5, 8'd8, 2'd0, 1), tag == "" ? "R7" : tag);
      end
    endcase
  endtask

  task automatic pulse(logic [7:0] bits);
    @(negedge clk);
    req_set = bits;
    @(negedge clk);
    req_set = '0;
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || cmd_val) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(n < 2000, "R2", "drain timed out, expected packet never issued");
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: drives ack for the coming edge, then compares the presented flit
  always @(negedge clk) begin
    logic [84:0] got;
    cyc++;
    cmd_ack = (ack_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    got = {cmd_addr, cmd_wdata, cmd_be, cmd_type, cmd_plen, cmd_code, cmd_eop};
    if (rst_n) begin
      if (idle_due) begin
        check(!cmd_val, "R12", $sformatf("cmd_val=%0b expected 0 after last flit", cmd_val));
        idle_due = 0;
      end else if (cmd_val) begin
        if (q.size() == 0) begin
          check(0, "R3", $sformatf("unexpected flit %h, expected none", got));
        end else begin
          check(got == q[0].bits, cmd_ack ? q[0].tag : "R11",
                $sformatf("flit actual=%h expected=%h", got, q[0].bits));
          if (cmd_type inside {3'd5, 3'd6, 3'd7})
            check(cmd_addr[1:0] == 2'b00, "R10", $sformatf("addr low=%0d expected 0", cmd_addr[1:0]));
          if (cmd_ack) begin
            if (q[0].bits[0]) idle_due = 1;
            void'(q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    d_addr = 32'h1234_5677; i_addr = 32'h0040_0ABE; wr_addr = 32'h0000_8003;
    wr_data = 32'hCAFE_0001; wr_be = 4'b0110; sc_key = 32'h0000_00A5;
    sc_data = 32'h5555_AAAA; cas_old = 32'h1111_0000; cas_new = 32'h2222_0000;
    wb_hold_addr = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: nothing issued after reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!cmd_val, "R1", $sformatf("cmd_val=%0b expected 0", cmd_val));
    end

    // each kind alone, full acknowledge
    for (int k = 0; k < 8; k++) begin
      push_req(k, "");
      pulse(8'd1 << k);
      drain();
    end

    // same kinds under stalled acknowledge (R11 holds)
    ack_mode = 1;
    for (int k = 0; k < 8; k++) begin
      push_req(k, "");
      pulse(8'd1 << k);
      drain();
    end

    // R3: all eight at once, issued in priority order
    for (int k = 0; k < 8; k++) push_req(k, "R3");
    pulse(8'hFF);
    drain();

    // R4: same-word hazard blocks LL, SC goes past it
    d_addr = 32'h0000_2040; sc_key = 32'h0000_0077; sc_data = 32'hDEAD_BEEF;
    wb_hold = 1; wb_hold_addr = 32'h0000_2042;
    push_req(6, "R4");
    pulse(8'b0110_0000);
    drain();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!cmd_val, "R4", $sformatf("cmd_val=%0b expected 0 while hazard", cmd_val));
    end
    // R2: held LL flag persists and goes once hazard clears
    push_req(5, "R2");
    wb_hold = 0;
    drain();
    // R4: different word does not block
    wb_hold = 1; wb_hold_addr = 32'h0000_2044;
    push_req(5, "R4");
    pulse(8'b0010_0000);
    drain();
    wb_hold = 0;

    // R2: request raised during a CAS is kept and issued next
    ack_mode = 0;
    cas_old = 32'h0000_0003; cas_new = 32'h0000_0004;
    push_req(7, "R7");
    push_req(0, "R2");
    @(negedge clk);
    req_set = 8'h80;
    @(negedge clk);
    req_set = 8'h01;
    @(negedge clk);
    req_set = 8'h00;
    drain();

    // R2: a write raised during an SC, with the SC stalled
    ack_mode = 1;
    push_req(6, "R6");
    push_req(4, "R2");
    pulse(8'h40);
    pulse(8'h10);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule